// File: doc/BRIEF.md
# Double-Edge Pixel Port Realigner

This block sits at a pixel input port where the source sends each pixel as two half-words. One half-word arrives on the rising clock edge and the other on the falling edge. The block samples the bus on both edges and moves the falling-edge sample into the rising-edge domain. It then re-pairs the halves into full pixels. Every output changes on the rising edge only.

Sources do not always follow the expected ordering, so three control inputs correct for this. A swap control exchanges the two halves within the output word. A falling-delay control holds the falling-edge half back by one clock period, and a rising-delay control does the same for the rising-edge half. With these settings a pixel can be recovered when it begins on the falling edge, when its halves arrive in reversed order, or when both happen. An output flag marks the cycles whose pixel is built only from samples taken after reset.

Top module: `ddr_pixel_realign`

## Requirements
- R1: While `rst_n` is low, each rising edge clears `pix_out` to zero and drops `pix_vld`. All controls are inputs, and the bench holds them at 0 during reset.
- R2: Terminology for the rest of this list:
  - Rising edge p counts from 0, where edge 0 is the first rising edge with `rst_n` high.
  - Rk is the bus value sampled at rising edge k.
  - Fk is the bus value sampled at the falling edge that follows edge k.

  With all controls at 0, after rising edge p the output is `pix_out = {R(p-1), F(p-1)}`. The rising-edge half occupies bits [2*HALF_W-1:HALF_W].
- R3: With only `swap_en` set, after edge p the output is `pix_out = {F(p-1), R(p-1)}`.
- R4: With `dly_fall_en` set, the falling half used after edge p is F(p-2) in place of F(p-1).
- R5: With `dly_rise_en` set, the rising half used after edge p is R(p-2) in place of R(p-1). The swap and the delays combine freely.
- R6: `pix_vld` behaves as follows:
  - It is 0 after edge 0.
  - After edge 1 it is 1 only if no delay control is sampled high at that edge.
  - It is 1 after every edge p >= 2.
  - Once high, it stays high until reset.
- R7: The controls are sampled at each rising edge, and they set the pairing of the pixel produced at that edge. A change therefore applies to the very next output pixel.
- R8: Each of four source patterns recovers the original pixel {A,B} when its matching setting is used:
  - A on the rising edge, B on the following falling edge: no controls set.
  - B on the rising edge, A on the following falling edge: swap.
  - A on a falling edge, B on the next rising edge: swap plus falling delay.
  - B on a falling edge, A on the next rising edge: falling delay alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| half_in | input | HALF_W | Multiplexed half-word bus |
| swap_en | input | 1 | Exchange the two halves in the output word |
| dly_fall_en | input | 1 | Use the falling-edge half from one period earlier |
| dly_rise_en | input | 1 | Use the rising-edge half from one period earlier |
| pix_out | output | 2*HALF_W | Re-paired pixel word |
| pix_vld | output | 1 | Pixel built only from post-reset samples |

## Verification
The bench builds the block with the default half-word width of 12 bits, which gives 24-bit pixels. Each half is filled with a distinct pattern per period, so any mis-pairing or half exchange shows up as a value mismatch. At that width, every one of the eight control combinations runs against fresh data, and the four ordered source patterns run against known pixel lists. Control changes at segment boundaries exercise the per-pixel switch-over and the one-period fill of the delay path.

// File: rtl/ddrpix_pkg.sv
// Package: shared control type for the double-edge pixel realigner.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package ddrpix_pkg;

    // Pairing controls sampled on each rising edge.
    typedef struct packed {
        logic swap;      // exchange halves in the output word
        logic dly_fall;  // take falling half from one period earlier
        logic dly_rise;  // take rising half from one period earlier
    } pair_ctrl_t;

endpackage

// File: rtl/ddrpix_edge_capture.sv
// Module: ddrpix_edge_capture
// Samples the multiplexed bus on the rising edge and on the falling edge.
// Assumes the bus is stable around both edges; the falling sample is held
// through the next rising edge, where downstream logic picks it up.
module ddrpix_edge_capture #(
    parameter int HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_in,
    output logic [HALF_W-1:0] rise_cur,
    output logic [HALF_W-1:0] fall_cur
);

    // Rising-edge sample of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_cur <= '0;
        else        rise_cur <= half_in;
    end

    // Falling-edge sample of the current period.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_cur <= '0;
        else        fall_cur <= half_in;
    end

endmodule

// File: rtl/ddrpix_half_delay.sv
// Module: ddrpix_half_delay
// Holds one half-word stream back by a single rising-edge clock period.
// Assumes the input is stable at the rising edge, which also makes this
// the second domain-crossing register for falling-edge data.
module ddrpix_half_delay #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // One-period delay register.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/ddrpix_assemble.sv
// Module: ddrpix_assemble
// Selects current or delayed halves, applies the swap, and registers the
// pixel and its valid flag on the rising edge. Assumes the controls are
// sampled on the same rising edge that loads the output.
module ddrpix_assemble
    import ddrpix_pkg::*;
#(
    parameter int HALF_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pair_ctrl_t          ctrl,
    input  logic [HALF_W-1:0]   rise_cur,
    input  logic [HALF_W-1:0]   fall_cur,
    input  logic [HALF_W-1:0]   rise_old,
    input  logic [HALF_W-1:0]   fall_old,
    output logic [2*HALF_W-1:0] pix_out,
    output logic                pix_vld
);

    localparam int PIX_W    = 2 * HALF_W;
    localparam int FILL_MAX = 2;
    localparam int FILL_W   = $clog2(FILL_MAX + 1);

    logic [HALF_W-1:0] rise_sel;
    logic [HALF_W-1:0] fall_sel;
    logic [PIX_W-1:0]  pix_next;
    logic [FILL_W-1:0] fill_q;
    logic              any_dly;

    // Half selection and ordering for the pixel formed at this edge.
    always_comb begin
        rise_sel = ctrl.dly_rise ? rise_old : rise_cur;
        fall_sel = ctrl.dly_fall ? fall_old : fall_cur;
        pix_next = ctrl.swap ? {fall_sel, rise_sel} : {rise_sel, fall_sel};
        any_dly  = ctrl.dly_rise | ctrl.dly_fall;
    end

    // Count post-reset periods until the delay path is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)                           fill_q <= '0;
        else if (fill_q != FILL_W'(FILL_MAX)) fill_q <= fill_q + 1'b1;
    end

    // Output pixel and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out <= '0;
            pix_vld <= 1'b0;
        end else begin
            pix_out <= pix_next;
            pix_vld <= (fill_q != '0) &&
                       (!any_dly || fill_q == FILL_W'(FILL_MAX));
        end
    end

    AST_VLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_vld) |-> pix_vld); // R6

    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pix_out == '0 && !pix_vld)); // R1

endmodule

// File: rtl/ddr_pixel_realign.sv
// Module: ddr_pixel_realign (top)
// Rebuilds full pixels from a bus carrying half a pixel on each clock edge.
// Assumes one clock for both edges and synchronous active-low reset; all
// outputs change on the rising edge only.
module ddr_pixel_realign
    import ddrpix_pkg::*;
#(
    parameter int HALF_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HALF_W-1:0]   half_in,
    input  logic                swap_en,
    input  logic                dly_fall_en,
    input  logic                dly_rise_en,
    output logic [2*HALF_W-1:0] pix_out,
    output logic                pix_vld
);

    localparam int LANES = 2;  // lane 0 = rising half, lane 1 = falling half

    logic [HALF_W-1:0] lane_cur [LANES];
    logic [HALF_W-1:0] lane_old [LANES];
    pair_ctrl_t        ctrl;

    // Pack the control pins into the shared control type.
    always_comb begin
        ctrl.swap     = swap_en;
        ctrl.dly_fall = dly_fall_en;
        ctrl.dly_rise = dly_rise_en;
    end

    ddrpix_edge_capture #(.HALF_W(HALF_W)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_in  (half_in),
        .rise_cur (lane_cur[0]),
        .fall_cur (lane_cur[1])
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ddrpix_half_delay #(.W(HALF_W)) i_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (lane_cur[g]),
            .q     (lane_old[g])
        );
    end

    ddrpix_assemble #(.HALF_W(HALF_W)) i_assemble (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .rise_cur (lane_cur[0]),
        .fall_cur (lane_cur[1]),
        .rise_old (lane_old[0]),
        .fall_old (lane_old[1]),
        .pix_out  (pix_out),
        .pix_vld  (pix_vld)
    );

    AST_PLAIN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $past({swap_en, dly_fall_en, dly_rise_en}) == 3'b000
        |-> pix_out == {$past(lane_cur[0]), $past(lane_cur[1])}); // R2

    AST_SWAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $past({swap_en, dly_fall_en, dly_rise_en}) == 3'b100
        |-> pix_out == {$past(lane_cur[1]), $past(lane_cur[0])}); // R3

    AST_FALL_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past({swap_en, dly_fall_en, dly_rise_en}) == 3'b010
        |-> pix_out[HALF_W-1:0] == $past(lane_cur[1], 2)); // R4

    AST_RISE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past({swap_en, dly_fall_en, dly_rise_en}) == 3'b001
        |-> pix_out[2*HALF_W-1:HALF_W] == $past(lane_cur[0], 2)); // R5

endmodule

// File: tb/test_ddr_pixel_realign.sv
// Bench: drives per-period rising and falling half-words from arrays and
// compares every output against a behavioural model of the pairing rules.
module test_ddr_pixel_realign;

    localparam int HW   = 12;
    localparam int SEGL = 40;
    localparam int NSEG = 12;
    localparam int NP   = SEGL * NSEG;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [HW-1:0] half_in;
    logic          swap_en, dly_fall_en, dly_rise_en;
    logic [2*HW-1:0] pix_out;
    logic          pix_vld;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [HW-1:0]   r_arr [0:NP+1];
    logic [HW-1:0]   f_arr [0:NP+1];
    logic [2*HW-1:0] p_arr [0:NP+1];
    logic [2:0]      seg_ctrl [0:NSEG-1];  // {swap, dly_fall, dly_rise}

    always #10 clk = ~clk;  // 50 MHz

    ddr_pixel_realign #(.HALF_W(HW)) i_ddr_pixel_realign (
        .clk(clk), .rst_n(rst_n), .half_in(half_in),
        .swap_en(swap_en), .dly_fall_en(dly_fall_en), .dly_rise_en(dly_rise_en),
        .pix_out(pix_out), .pix_vld(pix_vld)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] ctrl_at(input int p);
        int s = p / SEGL;
        if (s > NSEG - 1) s = NSEG - 1;
        return seg_ctrl[s];
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b000:  return "R2";
            3'b100:  return "R3";
            3'b010:  return "R4";
            3'b001:  return "R5";
            default: return "R7";
        endcase
    endfunction

    // Build source data: four ordered patterns, then eight control combos.
    initial begin
        for (int i = 0; i <= NP + 1; i++) begin
            r_arr[i] = HW'((i * 37 + 5) ^ 12'h5A3);
            f_arr[i] = HW'((i * 91 + 17) ^ 12'hC3C);
            p_arr[i] = {HW'(i * 53 + 9), HW'((i * 29 + 300) ^ 12'h0F0)};
        end
        seg_ctrl[0] = 3'b000; seg_ctrl[1] = 3'b100;
        seg_ctrl[2] = 3'b110; seg_ctrl[3] = 3'b010;
        for (int c = 0; c < 8; c++) seg_ctrl[4 + c] = {c[0], c[1], c[2]};
        for (int s = 0; s < 4; s++) begin
            for (int j = s * SEGL; j < (s + 1) * SEGL; j++) begin
                case (s)
                    0: begin r_arr[j] = p_arr[j][2*HW-1:HW]; f_arr[j] = p_arr[j][HW-1:0]; end
                    1: begin r_arr[j] = p_arr[j][HW-1:0]; f_arr[j] = p_arr[j][2*HW-1:HW]; end
                    2: begin f_arr[j] = p_arr[j][2*HW-1:HW]; r_arr[j+1] = p_arr[j][HW-1:0]; end
                    default: begin f_arr[j] = p_arr[j][HW-1:0]; r_arr[j+1] = p_arr[j][2*HW-1:HW]; end
                endcase
            end
        end
    end

    // Stimulus and per-cycle comparison against the model.
    initial begin
        rst_n = 1'b0; half_in = '0;
        {swap_en, dly_fall_en, dly_rise_en} = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pix_out", 32'(pix_out), 32'h0);
        check("R1 reset pix_vld", 32'(pix_vld), 32'h0);
        #5;
        rst_n = 1'b1;
        half_in = r_arr[0];
        {swap_en, dly_fall_en, dly_rise_en} = ctrl_at(0);
        for (int p = 0; p < NP; p++) begin
            logic [2:0]      c;
            logic            v_exp;
            logic [HW-1:0]   rh, fh;
            logic [2*HW-1:0] px;
            int              s;
            @(posedge clk);
            #5 half_in = f_arr[p];
            @(negedge clk);
            c = ctrl_at(p);
            v_exp = (p >= 2) || (p == 1 && c[1:0] == 2'b00);
            check("R6 valid", 32'(pix_vld), 32'(v_exp));
            if (v_exp) begin
                rh = c[0] ? r_arr[p-2] : r_arr[p-1];
                fh = c[1] ? f_arr[p-2] : f_arr[p-1];
                px = c[2] ? {fh, rh} : {rh, fh};
                check(tag_of(c), 32'(pix_out), 32'(px));
            end
            s = p / SEGL;
            if (s < 4 && p >= s * SEGL + 3) begin
                check("R8 recover", 32'(pix_out), 32'(s < 2 ? p_arr[p-1] : p_arr[p-2]));
            end
            #5;
            half_in = r_arr[p+1];
            {swap_en, dly_fall_en, dly_rise_en} = ctrl_at(p + 1);
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                #(200000 * 20);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule